// File: doc/BRIEF.md
# Peripheral Interrupt Priority Router

This block takes 64 level-sensitive peripheral interrupt lines and steers each one onto one of seven core priority request lines. Software picks the level for each source by writing a 4-bit route field, and it enables or disables each source with a mask bit. The mask bits are kept in two 32-bit banks. Each clock the block samples the raw lines into status registers. A source is active only when both its status bit and its mask bit are set. The block then raises one request per level for every level that has at least one active source routed to it.

When the core takes a level, it asks the router which source caused it. The router answers one cycle later with the lowest-numbered active source on that level. If no active source is routed there, it answers with a spurious flag instead. A plain word-wide register port reads and writes the route registers and the mask banks, and it reads the status banks.

Top module: `pic_router`

## Requirements
- R1: After reset every route register and both mask banks read 0, all lvlReq bits are 0 and qryDone is 0.
- R2: Route registers sit at addresses 0 to 7. Source n uses the 4-bit field in register n>>3 at bits (n&7)*4+3 down to (n&7)*4. A field value k from 0 to 6 sends the source to lvlReq bit k. Each route register reads back what was last written to it.
- R3: Address 8 holds the mask for sources 0 to 31 and address 9 holds the mask for sources 32 to 63. Bit b of bank j belongs to source 32*j+b, and a 1 enables that source. A write to one bank leaves the other bank unchanged.
- R4: Address 10 reads the status of sources 0 to 31 and address 11 reads sources 32 to 63. Each status bit is the irqIn line as sampled at the last rising clock edge. Writes to these two addresses change nothing.
- R5: lvlReq bit k is 1 exactly when some source has its status bit, its mask bit and a route field equal to k all set. The bit reflects irqIn and register contents with a latency of two rising edges after an irqIn change and one rising edge after a register write.
- R6: Route field values 7 to 15 leave a source unassigned. Such a source never raises any lvlReq bit and is never reported by a query.
- R7: A query is a qryReq pulse carrying qryLvl, sampled on a rising edge. On that edge qryDone goes to 1 for one cycle. At the same time qrySrc takes the lowest-numbered active source whose route field equals qryLvl, and qrySpurious takes 0.
- R8: When no active source is routed to the queried level, or qryLvl is 7, the query answers with qrySpurious = 1 and qrySrc = 0.
- R9: Addresses 12 to 15 read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irqIn | input | 64 | Level-sensitive peripheral interrupt lines |
| regAddr | input | 4 | Register word address |
| regWrEn | input | 1 | Write strobe for regWrData at regAddr |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| qryReq | input | 1 | Source query strobe |
| qryLvl | input | 3 | Level being queried (0 to 6 valid) |
| qryDone | output | 1 | Query answer valid, one cycle |
| qrySrc | output | 6 | Winning source number |
| qrySpurious | output | 1 | No active source on the queried level |
| lvlReq | output | 7 | Registered request per priority level |

## Verification
Several rules are checked on every cycle by the assertions. With all masks clear or all fields unassigned, the next cycle has no level requests. Every non-spurious answer names a source that was active on the queried level, and no lower-numbered source on that level was active. A spurious answer always comes with source 0 and no match. Write strobes are one-hot and never fire for unmapped addresses. Some behaviour only the bench's scenarios can show: the exact bit layout of the route fields, the independence of the two mask banks, the two-edge latency from irqIn to lvlReq, and read-back of every register. The bench checks these against a model, using directed cases and seeded random route, mask and input patterns.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  localparam int NUM_SRC     = 64;
  localparam int BANK_W      = 32;
  localparam int NUM_BANK    = NUM_SRC / BANK_W;
  localparam int FLD_W       = 4;
  localparam int FLD_PER_REG = BANK_W / FLD_W;
  localparam int NUM_CFG     = NUM_SRC / FLD_PER_REG;
  localparam int NUM_LVL     = 7;
  localparam int LVL_W       = $clog2(NUM_LVL);
  localparam int SRC_W       = $clog2(NUM_SRC);
  localparam int ADDR_W      = 4;
  localparam int IDX_W       = $clog2(NUM_CFG);
  localparam int MASK_BASE   = NUM_CFG;
  localparam int STAT_BASE   = NUM_CFG + NUM_BANK;
  localparam int MAP_END     = STAT_BASE + NUM_BANK;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CFG  = 2'd1,
    RD_MASK = 2'd2,
    RD_STAT = 2'd3
  } rdKind_e;

  typedef struct packed {
    logic [NUM_CFG-1:0]  wrCfg;
    logic [NUM_BANK-1:0] wrMask;
    logic                qryCap;
    rdKind_e             rdKind;
    logic [IDX_W-1:0]    rdIdx;
  } strobe_t;
endpackage

// File: rtl/pic_ctrl.sv
`timescale 1ns/1ps
module pic_ctrl
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              qryReq,
  output strobe_t           strb,
  output logic              qryDone
);

  always_comb begin
    strb        = '0;
    strb.rdKind = RD_NONE;
    strb.qryCap = qryReq;
    for (int i = 0; i < NUM_CFG; i++) begin
      if (regAddr == ADDR_W'(i)) begin
        strb.rdKind   = RD_CFG;
        strb.rdIdx    = IDX_W'(i);
        strb.wrCfg[i] = regWrEn;
      end
    end
    for (int b = 0; b < NUM_BANK; b++) begin
      if (regAddr == ADDR_W'(MASK_BASE + b)) begin
        strb.rdKind    = RD_MASK;
        strb.rdIdx     = IDX_W'(b);
        strb.wrMask[b] = regWrEn;
      end
      if (regAddr == ADDR_W'(STAT_BASE + b)) begin
        strb.rdKind = RD_STAT;
        strb.rdIdx  = IDX_W'(b);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qryDone <= 1'b0;
    else        qryDone <= qryReq;
  end

  // R2 R3: at most one register is written per cycle
  a_r3_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.wrCfg, strb.wrMask}));

  // R4 R9: status and unmapped addresses never produce a write strobe
  a_r9_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(regAddr) >= STAT_BASE) |-> ({strb.wrCfg, strb.wrMask} == '0));

endmodule

// File: rtl/pic_datapath.sv
`timescale 1ns/1ps
module pic_datapath
  import pic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            strb,
  input  logic [BANK_W-1:0]  regWrData,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [2:0]         qryLvl,
  output logic [BANK_W-1:0]  regRdData,
  output logic [NUM_LVL-1:0] lvlReq,
  output logic [SRC_W-1:0]   qrySrc,
  output logic               qrySpurious
);

  logic [BANK_W-1:0]  cfgReg  [NUM_CFG];
  logic [BANK_W-1:0]  maskReg [NUM_BANK];
  logic [BANK_W-1:0]  statReg [NUM_BANK];
  logic [FLD_W-1:0]   fld     [NUM_SRC];
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] maskFlat;
  logic [NUM_SRC-1:0] qMatch;
  logic [NUM_LVL-1:0] lvlHit;
  logic [SRC_W-1:0]   findIdx;
  logic               found;
  logic               allUnassigned;

  // per-source field and effective pending views
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    assign fld[n]      = cfgReg[n / FLD_PER_REG][(n % FLD_PER_REG) * FLD_W +: FLD_W];
    assign maskFlat[n] = maskReg[n / BANK_W][n % BANK_W];
    assign pend[n]     = statReg[n / BANK_W][n % BANK_W] & maskFlat[n];
    assign qMatch[n]   = pend[n] && (qryLvl < 3'(NUM_LVL))
                         && (fld[n] == FLD_W'(qryLvl));
  end

  always_comb begin
    lvlHit        = '0;
    allUnassigned = 1'b1;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (fld[n] < FLD_W'(NUM_LVL)) begin
        allUnassigned = 1'b0;
        if (pend[n]) lvlHit[fld[n][LVL_W-1:0]] = 1'b1;
      end
    end
  end

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    found   = 1'b0;
    findIdx = '0;
    for (int n = NUM_SRC - 1; n >= 0; n--) begin
      if (qMatch[n]) begin
        found   = 1'b1;
        findIdx = SRC_W'(n);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CFG; i++) cfgReg[i] <= '0;
      for (int b = 0; b < NUM_BANK; b++) begin
        maskReg[b] <= '0;
        statReg[b] <= '0;
      end
      lvlReq      <= '0;
      qrySrc      <= '0;
      qrySpurious <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_CFG; i++)
        if (strb.wrCfg[i]) cfgReg[i] <= regWrData;
      for (int b = 0; b < NUM_BANK; b++) begin
        if (strb.wrMask[b]) maskReg[b] <= regWrData;
        statReg[b] <= irqIn[b * BANK_W +: BANK_W];
      end
      lvlReq <= lvlHit;
      if (strb.qryCap) begin
        qrySrc      <= findIdx;
        qrySpurious <= !found;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (strb.rdKind == RD_CFG && strb.rdIdx == IDX_W'(i)) regRdData = cfgReg[i];
    for (int b = 0; b < NUM_BANK; b++) begin
      if (strb.rdKind == RD_MASK && strb.rdIdx == IDX_W'(b)) regRdData = maskReg[b];
      if (strb.rdKind == RD_STAT && strb.rdIdx == IDX_W'(b)) regRdData = statReg[b];
    end
  end

  // R5: nothing enabled means no request on the next cycle
  a_r5_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (maskFlat == '0) |=> (lvlReq == '0));

  // R6: all fields unassigned means no request on the next cycle
  a_r6_unassigned_silent: assert property (@(posedge clk) disable iff (!rst_n)
    allUnassigned |=> (lvlReq == '0));

  // R7: a reported source was active on the queried level
  a_r7_winner_active: assert property (@(posedge clk) disable iff (!rst_n)
    strb.qryCap |=> (qrySpurious || (|(($past(qMatch) >> qrySrc) & NUM_SRC'(1)))));

  // R7: no lower-numbered source on that level was active
  a_r7_winner_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    strb.qryCap |=> (qrySpurious
                     || (($past(qMatch) & ((NUM_SRC'(1) << qrySrc) - NUM_SRC'(1))) == '0)));

  // R8: spurious answers carry source 0 and had no candidate
  a_r8_spurious_zero: assert property (@(posedge clk) disable iff (!rst_n)
    qrySpurious |-> (qrySrc == '0));
  a_r8_spurious_empty: assert property (@(posedge clk) disable iff (!rst_n)
    strb.qryCap |=> (!qrySpurious || ($past(qMatch) == '0)));

endmodule

// File: rtl/pic_router.sv
`timescale 1ns/1ps
module pic_router
  import pic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [BANK_W-1:0]  regWrData,
  output logic [BANK_W-1:0]  regRdData,
  input  logic               qryReq,
  input  logic [2:0]         qryLvl,
  output logic               qryDone,
  output logic [SRC_W-1:0]   qrySrc,
  output logic               qrySpurious,
  output logic [NUM_LVL-1:0] lvlReq
);

  strobe_t strb;

  pic_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .qryReq  (qryReq),
    .strb    (strb),
    .qryDone (qryDone)
  );

  pic_datapath u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .regWrData   (regWrData),
    .irqIn       (irqIn),
    .qryLvl      (qryLvl),
    .regRdData   (regRdData),
    .lvlReq      (lvlReq),
    .qrySrc      (qrySrc),
    .qrySpurious (qrySpurious)
  );

endmodule

// File: tb/pic_router_bench.sv
`timescale 1ns/1ps
module pic_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irqIn = '0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        qryReq = 1'b0;
  logic [2:0]  qryLvl = '0;
  logic        qryDone;
  logic [5:0]  qrySrc;
  logic        qrySpurious;
  logic [6:0]  lvlReq;

  int checks = 0;
  int failures = 0;

  logic [31:0] mCfg [8];
  logic [31:0] mMask [2];
  logic [63:0] mIrq;

  always #4 clk = ~clk;

  pic_router u_pic_router (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .qryReq(qryReq), .qryLvl(qryLvl), .qryDone(qryDone), .qrySrc(qrySrc),
    .qrySpurious(qrySpurious), .lvlReq(lvlReq)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] fieldOf(input int n);
    return mCfg[n >> 3][(n & 7) * 4 +: 4];
  endfunction

  function automatic bit activeOf(input int n);
    return mIrq[n] && mMask[n / 32][n % 32];
  endfunction

  function automatic logic [6:0] expLvl();
    logic [6:0] r = '0;
    for (int n = 0; n < 64; n++)
      if (activeOf(n) && fieldOf(n) < 4'd7) r[fieldOf(n)] = 1'b1;
    return r;
  endfunction

  // returns {spurious, src}
  function automatic logic [6:0] expQry(input logic [2:0] lvl);
    if (lvl != 3'd7)
      for (int n = 0; n < 64; n++)
        if (activeOf(n) && fieldOf(n) == {1'b0, lvl}) return {1'b0, 6'(n)};
    return 7'b1000000;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a < 4'd8) mCfg[a[2:0]] = d;
    else if (a < 4'd10) mMask[a[0]] = d;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic setIrq(input logic [63:0] v);
    @(negedge clk);
    irqIn = v; mIrq = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic query(input logic [2:0] lvl, input string tag);
    logic [6:0] e;
    e = expQry(lvl);
    @(negedge clk);
    qryReq = 1'b1; qryLvl = lvl;
    @(negedge clk);
    qryReq = 1'b0;
    #1;
    check(qryDone === 1'b1, {tag, " qryDone"}, 64'(qryDone), 64'd1);
    check({qrySpurious, qrySrc} === e, {tag, " answer"}, 64'({qrySpurious, qrySrc}), 64'(e));
    @(negedge clk);
    check(qryDone === 1'b0, {tag, " qryDone pulse"}, 64'(qryDone), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 8; i++) mCfg[i] = '0;
    mMask[0] = '0; mMask[1] = '0; mIrq = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    check(lvlReq === 7'd0, "R1 lvlReq", 64'(lvlReq), 0);
    check(qryDone === 1'b0, "R1 qryDone", 64'(qryDone), 0);
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d);
      check(d === 32'd0, "R1 register", 64'(d), 0);
    end

    // R2 field layout: reg 3 fields 0..7 hold 0..7 -> source 29 on level 5
    wr(4'd3, 32'h76543210);
    rd(4'd3, d);
    check(d === 32'h76543210, "R2 readback", 64'(d), 64'h76543210);
    wr(4'd8, 32'hFFFFFFFF);
    wr(4'd9, 32'hFFFFFFFF);
    setIrq(64'h0000_0000_2000_0000);
    check(lvlReq === 7'b0100000, "R2 source 29 level", 64'(lvlReq), 64'h20);
    query(3'd5, "R2 query");

    // R5 latency: lvlReq follows irqIn two edges later
    @(negedge clk);
    irqIn = 64'h0000_0000_0400_0000; mIrq = irqIn;   // source 26 -> field 2
    @(negedge clk);
    check(lvlReq === 7'b0100000, "R5 one edge old", 64'(lvlReq), 64'h20);
    @(negedge clk);
    check(lvlReq === 7'b0000100, "R5 two edges new", 64'(lvlReq), 64'h04);

    // R3 bank independence
    wr(4'd8, 32'hA5A5_0F0F);
    wr(4'd9, 32'h1234_5678);
    wr(4'd8, 32'h0000_00FF);
    rd(4'd9, d);
    check(d === 32'h1234_5678, "R3 bank1 kept", 64'(d), 64'h12345678);
    rd(4'd8, d);
    check(d === 32'h0000_00FF, "R3 bank0 new", 64'(d), 64'hFF);

    // R4 status read and write-ignore
    setIrq(64'hDEAD_BEEF_0BAD_F00D);
    rd(4'd10, d);
    check(d === 32'h0BAD_F00D, "R4 status bank0", 64'(d), 64'h0BADF00D);
    wr(4'd11, 32'h0);
    rd(4'd11, d);
    check(d === 32'hDEAD_BEEF, "R4 status bank1 write ignored", 64'(d), 64'hDEADBEEF);

    // R6 unassigned values
    for (int i = 0; i < 8; i++) wr(4'(i), (i % 2 == 0) ? 32'hFFFFFFFF : 32'h77777777);
    wr(4'd8, 32'hFFFFFFFF);
    wr(4'd9, 32'hFFFFFFFF);
    setIrq('1);
    check(lvlReq === 7'd0, "R6 no request", 64'(lvlReq), 0);
    query(3'd0, "R6 not reported");

    // R7 lowest source wins within a level
    for (int i = 0; i < 8; i++) wr(4'(i), 32'h11111111);
    setIrq(64'h0004_0100_0000_1000);  // sources 12, 40, 50
    query(3'd1, "R7 lowest 12");
    wr(4'd8, 32'hFFFF_EFFF);
    @(negedge clk);
    query(3'd1, "R7 next lowest 40");

    // R8 spurious
    query(3'd3, "R8 empty level");
    query(3'd7, "R8 level 7");

    // R9 unmapped addresses
    for (int a = 12; a < 16; a++) begin
      wr(4'(a), 32'h0);
      rd(4'(a), d);
      check(d === 32'd0, "R9 unmapped reads 0", 64'(d), 0);
    end
    rd(4'd9, d);
    check(d === mMask[1], "R9 mask untouched", 64'(d), 64'(mMask[1]));
    rd(4'd5, d);
    check(d === mCfg[5], "R9 route untouched", 64'(d), 64'(mCfg[5]));

    // R5 R7 random mix
    for (int it = 0; it < 250; it++) begin
      if (it % 10 == 0)
        for (int i = 0; i < 8; i++) begin
          logic [31:0] v;
          for (int f = 0; f < 8; f++) v[f*4 +: 4] = 4'($urandom % 9);
          wr(4'(i), v);
        end
      if (it % 4 == 0) wr(4'd8 + 4'($urandom % 2), $urandom | $urandom);
      setIrq({$urandom & $urandom, $urandom & $urandom});
      check(lvlReq === expLvl(), "R5 random lvlReq", 64'(lvlReq), 64'(expLvl()));
      query(3'($urandom % 8), "R7 random query");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule